// File: doc/BRIEF.md
# Dual-Width Host Bus Interface

This block is the host-side data path in front of a memory of 256K 16-bit words that can also be addressed as 512K bytes. It samples the chip select, read strobe, write strobe and width select from the host. On reads it steers one of four 16-bit read sources onto the bus lanes and raises a separate drive flag for each 8-bit lane. On writes it catches the address and the bus data when the write strobe goes high again.

The width select picks one of two modes. In 16-bit mode both lanes carry data and the extra byte-address bit is ignored. In 8-bit mode all traffic uses the low lane, the high lane is never driven, and the extra address bit picks the upper or lower half of the addressed word. A status read is narrower than the bus, so it drives only the low lane in either mode. The array contents and the command decoding sit outside this block.

All outputs are registered. A change at the inputs shows at the outputs after the next rising clock edge.

Top module: `dual_width_bus_if`

## Requirements
- R1: While `rst_n` is low, `lo_drive`, `hi_drive`, `wr_stb`, `wr_lsb`, `dq_out`, `wr_addr` and `wr_data` are all zero.
- R2: If `ce_n` is high, `oe_n` is high or `we_n` is low at a rising clock edge, then `lo_drive` and `hi_drive` are both low after that edge.
- R3: In 16-bit mode (`byte_n` = 1), a read of a non-status source with `ce_n` = 0, `oe_n` = 0 and `we_n` = 1 sets both drive flags after the edge, and `dq_out` then holds the full 16-bit source word.
- R4: In 8-bit mode (`byte_n` = 0), a read sets only `lo_drive`. `dq_out[7:0]` holds bits 15:8 of the source word when `addr_lsb` = 1 and bits 7:0 when `addr_lsb` = 0, and `dq_out[15:8]` is zero.
- R5: In 16-bit mode, `addr_lsb` has no effect on `dq_out` or on the captured write.
- R6: A status read (`rd_src` = 3) sets `lo_drive` but never `hi_drive`, in either mode. `dq_out[7:0]` holds `stat_rdata` and `dq_out[15:8]` is zero.
- R7: `rd_src` picks the read source: 0 is `arr_rdata`, 1 is `buf_rdata`, 2 is `id_rdata` and 3 is `stat_rdata`.
- R8: A write is captured at the first rising clock edge that sees `we_n` = 1 after an edge that saw `we_n` = 0, with `ce_n` = 0 at the capturing edge. After that edge `wr_stb` is high for exactly one cycle, and `wr_addr` holds `addr` as sampled at that edge.
- R9: A 16-bit write loads all of `dq_in` into `wr_data` and sets `wr_lsb` to 0.
- R10: An 8-bit write copies `dq_in[7:0]` into one half of `wr_data`, which stays unchanged otherwise. The upper half is written when `addr_lsb` = 1 and the lower half when it is 0. `dq_in[15:8]` is ignored, and `addr_lsb` is latched into `wr_lsb`.
- R11: A write-strobe pulse with `ce_n` high produces no `wr_stb`, and it leaves `wr_data`, `wr_addr` and `wr_lsb` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low; capture happens on its rise |
| byte_n | input | 1 | Width select: 0 selects 8-bit mode, 1 selects 16-bit mode |
| addr | input | 18 | Word address |
| addr_lsb | input | 1 | Byte address bit, used only in 8-bit mode |
| dq_in | input | 16 | Bus data arriving from the host |
| rd_src | input | 2 | Read source: 0 array, 1 buffer, 2 identifier, 3 status |
| arr_rdata | input | 16 | Array read word |
| buf_rdata | input | 16 | Buffer read word |
| id_rdata | input | 16 | Identifier read word |
| stat_rdata | input | 8 | Status byte |
| dq_out | output | 16 | Registered bus data going to the host |
| lo_drive | output | 1 | Registered drive flag for lane 7:0 |
| hi_drive | output | 1 | Registered drive flag for lane 15:8 |
| wr_stb | output | 1 | One-cycle pulse marking a captured write |
| wr_addr | output | 18 | Latched write word address |
| wr_lsb | output | 1 | Latched byte address bit of the write |
| wr_data | output | 16 | Latched, byte-merged write word |

## Verification
Reads use a distinct word on every source, so a wrong source pick or a swapped half shows up in `dq_out`. Each read is repeated with `addr_lsb` at both values in both modes: in 8-bit mode this tells the two halves apart, and in 16-bit mode it shows the bit is ignored. Status reads run in 16-bit mode to show the upper lane stays undriven there too. Float tests raise `ce_n` and then `oe_n` alone. Writes put different bytes on the upper and lower lanes, so a byte-mode write that wrongly uses `dq_in[15:8]` or touches the other half is caught. A strobe pulse with the chip deselected must leave every latched output as it was.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_BUFFER = 2'd1,
      SRC_IDENT  = 2'd2,
      SRC_STATUS = 2'd3
   } rd_src_e;
endpackage

// File: rtl/dwb_lane_ctrl.sv
module dwb_lane_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic wide,
   input  logic is_status,
   output logic lo_drv,
   output logic hi_drv
);
   logic rd_act;

   // a read is active only with chip selected, read strobe low and no write strobe
   assign rd_act = ~ce_n & ~oe_n & we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_drv <= 1'b0;
         hi_drv <= 1'b0;
      end else begin
         lo_drv <= rd_act;
         hi_drv <= rd_act & wide & ~is_status;
      end
   end
endmodule

// File: rtl/dwb_rd_steer.sv
module dwb_rd_steer
   import dwb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int STAT_W = 8,
   localparam int LANE_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_src_e           src,
   input  logic              wide,
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] arr_word,
   input  logic [DATA_W-1:0] buf_word,
   input  logic [DATA_W-1:0] id_word,
   input  logic [STAT_W-1:0] stat_byte,
   output logic [DATA_W-1:0] dq
);
   logic [DATA_W-1:0] word;
   logic [LANE_W-1:0] lo_next;
   logic [LANE_W-1:0] hi_next;
   logic              is_status;
   logic              take_upper;

   always_comb begin
      case (src)
         SRC_ARRAY:  word = arr_word;
         SRC_BUFFER: word = buf_word;
         SRC_IDENT:  word = id_word;
         default:    word = '0;
      endcase
   end

   assign is_status  = (src == SRC_STATUS);
   assign take_upper = ~wide & byte_sel;

   for (genvar i = 0; i < LANE_W; i++) begin : g_lane
      logic stat_bit;
      if (i < STAT_W) begin : g_stat
         assign stat_bit = stat_byte[i];
      end else begin : g_pad
         assign stat_bit = 1'b0;
      end
      assign lo_next[i] = is_status  ? stat_bit :
                          take_upper ? word[LANE_W+i] : word[i];
      assign hi_next[i] = (wide & ~is_status) ? word[LANE_W+i] : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dq <= '0;
      else        dq <= {hi_next, lo_next};
   end
endmodule

// File: rtl/dwb_wr_latch.sv
module dwb_wr_latch #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16,
   localparam int LANE_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              wide,
   input  logic              byte_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              stb,
   output logic [ADDR_W-1:0] waddr,
   output logic              wsel,
   output logic [DATA_W-1:0] wdata
);
   logic              we_q;
   logic              capture;
   logic [DATA_W-1:0] merged;

   assign capture = ~ce_n & we_n & ~we_q;

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic upd;
      logic [LANE_W-1:0] src_b;
      assign upd   = wide | (byte_sel == h[0]);
      assign src_b = wide ? din[h*LANE_W +: LANE_W] : din[LANE_W-1:0];
      assign merged[h*LANE_W +: LANE_W] = upd ? src_b : wdata[h*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q  <= 1'b1;
         stb   <= 1'b0;
         waddr <= '0;
         wsel  <= 1'b0;
         wdata <= '0;
      end else begin
         we_q <= we_n;
         stb  <= capture;
         if (capture) begin
            waddr <= addr;
            wsel  <= ~wide & byte_sel;
            wdata <= merged;
         end
      end
   end
endmodule

// File: rtl/dual_width_bus_if.sv
module dual_width_bus_if
   import dwb_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16,
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              byte_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              addr_lsb,
   input  logic [DATA_W-1:0] dq_in,
   input  logic [1:0]        rd_src,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [DATA_W-1:0] buf_rdata,
   input  logic [DATA_W-1:0] id_rdata,
   input  logic [STAT_W-1:0] stat_rdata,
   output logic [DATA_W-1:0] dq_out,
   output logic              lo_drive,
   output logic              hi_drive,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_lsb,
   output logic [DATA_W-1:0] wr_data
);
   localparam int LANE_W = DATA_W / 2;

   if (DATA_W % 2 != 0 || DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be even and at least 2");
   end
   if (STAT_W < 1 || STAT_W > LANE_W) begin : g_bad_stat
      $error("STAT_W must fit in one lane");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   rd_src_e src;
   logic    wide;

   assign src  = rd_src_e'(rd_src);
   assign wide = byte_n;

   dwb_lane_ctrl u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .wide      (wide),
      .is_status (src == SRC_STATUS),
      .lo_drv    (lo_drive),
      .hi_drv    (hi_drive)
   );

   dwb_rd_steer #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src),
      .wide      (wide),
      .byte_sel  (addr_lsb),
      .arr_word  (arr_rdata),
      .buf_word  (buf_rdata),
      .id_word   (id_rdata),
      .stat_byte (stat_rdata),
      .dq        (dq_out)
   );

   dwb_wr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .wide     (wide),
      .byte_sel (addr_lsb),
      .addr     (addr),
      .din      (dq_in),
      .stb      (wr_stb),
      .waddr    (wr_addr),
      .wsel     (wr_lsb),
      .wdata    (wr_data)
   );
endmodule

// File: rtl/dual_width_bus_if_chk.sv
module dual_width_bus_if_chk #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              byte_n,
   input logic [1:0]        rd_src,
   input logic              lo_drive,
   input logic              hi_drive,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data
);
   AST_FLOAT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n || !we_n) |=> (!lo_drive && !hi_drive)); // R2
   AST_HI_WITH_LO: assert property (@(posedge clk) disable iff (!rst_n)
      hi_drive |-> lo_drive); // R3
   AST_BYTE_NO_HI: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_n |=> !hi_drive); // R4
   AST_STATUS_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_src == 2'd3) |=> !hi_drive); // R6
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R8
   AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !wr_stb); // R11
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |-> ($stable(wr_data) && $stable(wr_addr))); // R11
endmodule

bind dual_width_bus_if dual_width_bus_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dual_width_bus_if_test.sv
`timescale 1ns/1ps
module dual_width_bus_if_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1;
   logic [17:0] addr = '0;
   logic        addr_lsb = 1'b0;
   logic [15:0] dq_in = '0;
   logic [1:0]  rd_src = 2'd0;
   logic [15:0] arr_rdata = 16'h3C96, buf_rdata = 16'h1234, id_rdata = 16'hB0A7;
   logic [7:0]  stat_rdata = 8'h81;
   logic [15:0] dq_out;
   logic        lo_drive, hi_drive, wr_stb, wr_lsb;
   logic [17:0] wr_addr;
   logic [15:0] wr_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_width_bus_if uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .byte_n(byte_n), .addr(addr), .addr_lsb(addr_lsb), .dq_in(dq_in),
      .rd_src(rd_src), .arr_rdata(arr_rdata), .buf_rdata(buf_rdata),
      .id_rdata(id_rdata), .stat_rdata(stat_rdata), .dq_out(dq_out),
      .lo_drive(lo_drive), .hi_drive(hi_drive), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_data(wr_data)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_read(input logic bn, input logic lsb, input logic [1:0] src);
      byte_n = bn; addr_lsb = lsb; rd_src = src;
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      #3;
      chk("R1", "lo_drive", {31'd0, lo_drive}, 0);
      chk("R1", "hi_drive", {31'd0, hi_drive}, 0);
      chk("R1", "wr_stb", {31'd0, wr_stb}, 0);
      chk("R1", "dq_out", {16'd0, dq_out}, 0);
      chk("R1", "wr_data", {16'd0, wr_data}, 0);
      chk("R1", "wr_addr", {14'd0, wr_addr}, 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_wide_read();
      do_read(1'b1, 1'b0, 2'd0);
      chk("R3", "lo_drive", {31'd0, lo_drive}, 1);
      chk("R3", "hi_drive", {31'd0, hi_drive}, 1);
      chk("R3", "dq_out", {16'd0, dq_out}, 32'h3C96);
      do_read(1'b1, 1'b1, 2'd0);
      chk("R5", "dq_out lsb=1", {16'd0, dq_out}, 32'h3C96);
   endtask

   task automatic t_sources();
      do_read(1'b1, 1'b0, 2'd1);
      chk("R7", "buffer", {16'd0, dq_out}, 32'h1234);
      do_read(1'b1, 1'b0, 2'd2);
      chk("R7", "identifier", {16'd0, dq_out}, 32'hB0A7);
      do_read(1'b1, 1'b0, 2'd0);
      chk("R7", "array", {16'd0, dq_out}, 32'h3C96);
   endtask

   task automatic t_byte_read();
      do_read(1'b0, 1'b0, 2'd0);
      chk("R4", "low half", {16'd0, dq_out}, 32'h0096);
      chk("R4", "lo_drive", {31'd0, lo_drive}, 1);
      chk("R4", "hi_drive", {31'd0, hi_drive}, 0);
      do_read(1'b0, 1'b1, 2'd0);
      chk("R4", "high half", {16'd0, dq_out}, 32'h003C);
      do_read(1'b0, 1'b1, 2'd2);
      chk("R4", "id high half", {16'd0, dq_out}, 32'h00B0);
   endtask

   task automatic t_status();
      do_read(1'b1, 1'b0, 2'd3);
      chk("R6", "dq_out", {16'd0, dq_out}, 32'h0081);
      chk("R6", "lo_drive", {31'd0, lo_drive}, 1);
      chk("R6", "hi_drive", {31'd0, hi_drive}, 0);
      do_read(1'b0, 1'b1, 2'd3);
      chk("R6", "byte mode dq_out", {16'd0, dq_out}, 32'h0081);
   endtask

   task automatic t_float();
      do_read(1'b1, 1'b0, 2'd0);
      ce_n = 1'b1;
      tick();
      chk("R2", "ce_n high lo", {31'd0, lo_drive}, 0);
      chk("R2", "ce_n high hi", {31'd0, hi_drive}, 0);
      ce_n = 1'b0; oe_n = 1'b1;
      tick();
      chk("R2", "oe_n high lo", {31'd0, lo_drive}, 0);
      chk("R2", "oe_n high hi", {31'd0, hi_drive}, 0);
      oe_n = 1'b0;
      tick();
      chk("R2", "restored lo", {31'd0, lo_drive}, 1);
   endtask

   task automatic wr_pulse(input logic cen, input logic bn, input logic lsb,
                           input logic [17:0] a, input logic [15:0] d);
      oe_n = 1'b1; ce_n = cen; byte_n = bn; addr_lsb = lsb; addr = a; dq_in = d;
      we_n = 1'b0;
      tick();
      we_n = 1'b1;
      tick();
   endtask

   task automatic t_wide_write();
      wr_pulse(1'b0, 1'b1, 1'b1, 18'h2A5C3, 16'hABCD);
      chk("R8", "wr_stb", {31'd0, wr_stb}, 1);
      chk("R8", "wr_addr", {14'd0, wr_addr}, 32'h2A5C3);
      chk("R9", "wr_data", {16'd0, wr_data}, 32'hABCD);
      chk("R5", "wr_lsb ignored", {31'd0, wr_lsb}, 0);
      tick();
      chk("R8", "wr_stb drops", {31'd0, wr_stb}, 0);
   endtask

   task automatic t_byte_write();
      wr_pulse(1'b0, 1'b0, 1'b1, 18'h00011, 16'hFF5E);
      chk("R10", "upper merge", {16'd0, wr_data}, 32'h5ECD);
      chk("R10", "wr_lsb", {31'd0, wr_lsb}, 1);
      tick();
      wr_pulse(1'b0, 1'b0, 1'b0, 18'h00012, 16'hEE77);
      chk("R10", "lower merge", {16'd0, wr_data}, 32'h5E77);
      chk("R10", "wr_lsb low", {31'd0, wr_lsb}, 0);
      chk("R8", "wr_addr", {14'd0, wr_addr}, 32'h00012);
      tick();
   endtask

   task automatic t_desel_write();
      wr_pulse(1'b1, 1'b1, 1'b0, 18'h3FFFF, 16'h0000);
      chk("R11", "no wr_stb", {31'd0, wr_stb}, 0);
      chk("R11", "wr_data kept", {16'd0, wr_data}, 32'h5E77);
      chk("R11", "wr_addr kept", {14'd0, wr_addr}, 32'h00012);
      tick();
      chk("R11", "still no wr_stb", {31'd0, wr_stb}, 0);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      t_reset();
      t_wide_read();
      t_sources();
      t_byte_read();
      t_status();
      t_float();
      t_wide_write();
      t_byte_write();
      t_desel_write();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule